// File: doc/BRIEF.md
# SONET Framing Byte Generator with Test Corruption

This block produces the A1/A2 framing bytes of an STS-12 frame for several transmit channels in parallel. The framer around it supplies a pulse at the start of every frame and the index of the byte slot currently being emitted. For the 24 framing slots the block outputs the framing byte together with an overwrite flag, and the downstream multiplexer replaces the slot content when the flag is set. On every other slot the flag is low and the byte is zero.

For link testing, each channel can send deliberately wrong framing. The wrong A1 and A2 values and the burst length in frames are shared by all channels. Each channel has its own enable. A rising edge on a channel's enable arms a burst. Only the twelfth A1 byte and the first A2 byte of a corrupted frame carry the programmed values. A burst length of zero makes the corruption last until the enable drops. A global disable stops all framing insertion.

Top module: `framing_byte_gen`

## Requirements
- R1: With no corruption, slots 0 to 11 output 0xF6 and slots 12 to 23 output 0x28, each with the overwrite flag high. Slots 24 and above output flag 0 and byte 0x00.
- R2: The byte for a slot sampled at a clock edge appears at the outputs OUT_LAT (default 6) edges later. The first A1 byte therefore appears between 5 and 7 cycles after the frame pulse.
- R3: A rising edge of a channel's enable arms that channel. In each corrupted frame, slot 11 carries `cfg_a1` and slot 12 carries `cfg_a2`. The other 22 framing slots keep their normal values.
- R4: A channel armed with a nonzero count N corrupts exactly the next N frames whose pulse arrives while it is armed, and then disarms.
- R5: With a count of 0, corruption repeats on every frame until the enable is low at a frame pulse. That frame and later frames are normal.
- R6: After a burst ends, keeping the enable high starts no new burst. Clearing the enable and setting it again arms a fresh burst.
- R7: The count is captured when the channel arms. Writing `cfg_count` during a burst does not change the burst's length.
- R8: Enables act per channel. A channel that is not armed sends normal framing while another channel is corrupted.
- R9: While `ins_dis` is high, every channel outputs flag 0 and byte 0x00 on all slots. Frames that occur during this time still count toward an armed burst.
- R10: During reset all outputs are 0. An enable held high through reset does not arm the channel, so the first frame after reset is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | Frame start, high in the cycle of slot 0 |
| slot_pos | input | SLOT_W | Byte slot index within the frame |
| ins_dis | input | 1 | Global framing insertion disable |
| cfg_a1 | input | 8 | Shared corrupt value for the last A1 byte |
| cfg_a2 | input | 8 | Shared corrupt value for the first A2 byte |
| cfg_count | input | COUNT_W | Shared burst length in frames, 0 = endless |
| ch_en | input | NUM_CH | Per-channel corruption enable |
| ch_byte | output | NUM_CH*8 | Framing byte per channel, channel c at bits [8c+7:8c] |
| ch_ovr | output | NUM_CH | Per-channel overwrite flag |

## Verification
A wrong armed flag or a wrong frame count changes at most two bytes per frame: slot 11 and slot 12 of the next frame show a normal value where a corrupt one was expected, or the reverse. Such a fault therefore becomes visible within one frame plus the output latency. An off-by-one in the count shows up only at the end of a burst, so the frames just before and just after the end of each burst are compared byte for byte. A fault in the slot decode or the pipeline moves the flag window, and this is caught at the 24-slot boundaries of every frame checked.

// File: rtl/fbg_pkg.sv
// Shared constants and types for the framing byte generator.
package fbg_pkg;
    localparam logic [7:0] A1_NORMAL = 8'hF6;
    localparam logic [7:0] A2_NORMAL = 8'h28;

    // Role of a byte slot within the framing region.
    typedef enum logic [2:0] {
        SK_NONE,
        SK_A1,
        SK_A1_LAST,
        SK_A2_FIRST,
        SK_A2
    } slot_kind_e;
endpackage

// File: rtl/fbg_slot_decode.sv
// Classifies the incoming slot index into a framing role and registers it.
// Assumes slots 0..NUM_STS-1 are A1 and NUM_STS..2*NUM_STS-1 are A2.
module fbg_slot_decode
    import fbg_pkg::*;
#(
    parameter int NUM_STS = 12,
    parameter int SLOT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_pos,
    output slot_kind_e        kind_q
);
    localparam logic [SLOT_W-1:0] A1_LAST_POS = SLOT_W'(NUM_STS - 1);
    localparam logic [SLOT_W-1:0] A2_BASE     = SLOT_W'(NUM_STS);
    localparam logic [SLOT_W-1:0] A2_END      = SLOT_W'(2 * NUM_STS);

    slot_kind_e kind_d;

    // Map the slot index onto its framing role.
    always_comb begin
        if (slot_pos == A1_LAST_POS)      kind_d = SK_A1_LAST;
        else if (slot_pos < A1_LAST_POS)  kind_d = SK_A1;
        else if (slot_pos == A2_BASE)     kind_d = SK_A2_FIRST;
        else if (slot_pos < A2_END)       kind_d = SK_A2;
        else                              kind_d = SK_NONE;
    end

    // Register the role for the byte stage.
    always_ff @(posedge clk) begin
        if (!rst_n) kind_q <= SK_NONE;
        else        kind_q <= kind_d;
    end
endmodule

// File: rtl/fbg_chan_ctl.sv
// Per-channel corruption control. A rising enable arms a burst and captures
// the shared count. Each frame pulse while armed marks that frame as
// corrupted and consumes one count. Count 0 means the burst is endless.
// Assumes frame_pulse is a single-cycle pulse.
module fbg_chan_ctl #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse,
    input  logic               ch_en,
    input  logic [COUNT_W-1:0] cfg_count,
    output logic               corrupt_frame,
    output logic               armed,
    output logic               endless,
    output logic [COUNT_W-1:0] remain
);
    logic en_q;
    logic en_rise;

    // Previous enable value for edge detection. It tracks during reset, so an
    // enable held high through reset produces no rising edge.
    always_ff @(posedge clk) begin
        en_q <= ch_en;
    end

    assign en_rise = ch_en & ~en_q;

    // Arm, count down and latch the per-frame corruption decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed         <= 1'b0;
            endless       <= 1'b0;
            remain        <= '0;
            corrupt_frame <= 1'b0;
        end else begin
            if (frame_pulse) corrupt_frame <= armed & ch_en;
            if (!ch_en) begin
                armed <= 1'b0;
            end else if (en_rise) begin
                armed   <= 1'b1;
                remain  <= cfg_count;
                endless <= (cfg_count == '0);
            end else if (frame_pulse && armed && !endless) begin
                remain <= remain - COUNT_W'(1);
                if (remain == COUNT_W'(1)) armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fbg_delay.sv
// Fixed-depth register delay line with synchronous reset to zero.
// A DEPTH of 0 passes the input straight through.
module fbg_delay #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] pipe [DEPTH];

            // Shift the data one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign dout = pipe[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/framing_byte_gen.sv
// Multi-channel STS framing byte generator with test corruption.
// The output for a slot sampled at edge n appears after edge n+OUT_LAT.
// Assumes slot_pos advances by one each cycle and frame_pulse coincides
// with slot 0. ins_dis and cfg_a1/cfg_a2 are read at the byte stage.
module framing_byte_gen
    import fbg_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_STS = 12,
    parameter int SLOT_W  = 14,
    parameter int COUNT_W = 8,
    parameter int OUT_LAT = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_pulse,
    input  logic [SLOT_W-1:0]     slot_pos,
    input  logic                  ins_dis,
    input  logic [7:0]            cfg_a1,
    input  logic [7:0]            cfg_a2,
    input  logic [COUNT_W-1:0]    cfg_count,
    input  logic [NUM_CH-1:0]     ch_en,
    output logic [NUM_CH*8-1:0]   ch_byte,
    output logic [NUM_CH-1:0]     ch_ovr
);
    localparam int TAIL = (OUT_LAT > 1) ? OUT_LAT - 1 : 0;

    slot_kind_e                 kind_q;
    logic [NUM_CH-1:0]          armed_v;
    logic [NUM_CH-1:0]          endless_v;
    logic [NUM_CH*COUNT_W-1:0]  remain_v;

    fbg_slot_decode #(
        .NUM_STS (NUM_STS),
        .SLOT_W  (SLOT_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_pos (slot_pos),
        .kind_q   (kind_q)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic       corrupt_frame;
            logic [7:0] nxt_byte;
            logic       nxt_ovr;
            logic [7:0] byte_s;
            logic       ovr_s;
            logic [8:0] tail_out;

            fbg_chan_ctl #(
                .COUNT_W (COUNT_W)
            ) u_ctl (
                .clk           (clk),
                .rst_n         (rst_n),
                .frame_pulse   (frame_pulse),
                .ch_en         (ch_en[c]),
                .cfg_count     (cfg_count),
                .corrupt_frame (corrupt_frame),
                .armed         (armed_v[c]),
                .endless       (endless_v[c]),
                .remain        (remain_v[c*COUNT_W +: COUNT_W])
            );

            // Choose the framing byte for the current slot role.
            always_comb begin
                nxt_byte = 8'h00;
                nxt_ovr  = 1'b0;
                if (!ins_dis) begin
                    unique case (kind_q)
                        SK_A1:       begin nxt_byte = A1_NORMAL; nxt_ovr = 1'b1; end
                        SK_A1_LAST:  begin nxt_byte = corrupt_frame ? cfg_a1 : A1_NORMAL; nxt_ovr = 1'b1; end
                        SK_A2_FIRST: begin nxt_byte = corrupt_frame ? cfg_a2 : A2_NORMAL; nxt_ovr = 1'b1; end
                        SK_A2:       begin nxt_byte = A2_NORMAL; nxt_ovr = 1'b1; end
                        default:     begin nxt_byte = 8'h00; nxt_ovr = 1'b0; end
                    endcase
                end
            end

            // Byte stage register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_s <= 8'h00;
                    ovr_s  <= 1'b0;
                end else begin
                    byte_s <= nxt_byte;
                    ovr_s  <= nxt_ovr;
                end
            end

            fbg_delay #(
                .WIDTH (9),
                .DEPTH (TAIL)
            ) u_tail (
                .clk   (clk),
                .rst_n (rst_n),
                .din   ({ovr_s, byte_s}),
                .dout  (tail_out)
            );

            assign ch_ovr[c]          = tail_out[8];
            assign ch_byte[c*8 +: 8]  = tail_out[7:0];
        end
    endgenerate
endmodule

// File: rtl/fbg_checker.sv
// Protocol checks on the framing byte generator, attached by bind.
// Assumes the internal per-channel state vectors of the top module.
module fbg_checker #(
    parameter int NUM_CH  = 4,
    parameter int COUNT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_pulse,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH*8-1:0]      ch_byte,
    input logic [NUM_CH-1:0]        ch_ovr,
    input logic [NUM_CH-1:0]        armed,
    input logic [NUM_CH-1:0]        endless,
    input logic [NUM_CH*COUNT_W-1:0] remain
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_ovr[c] |-> ch_byte[c*8 +: 8] == 8'h00);

            p_arm_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_en[c] && !$past(ch_en[c])) |=> armed[c]);

            p_drop_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_en[c] |=> !armed[c]);

            p_no_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!armed[c] && ch_en[c] && $past(ch_en[c])) |=> !armed[c]);

            p_burst_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (armed[c] && frame_pulse && !endless[c]
                 && remain[c*COUNT_W +: COUNT_W] == COUNT_W'(1)) |=> !armed[c]);

            p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!frame_pulse && !(ch_en[c] && !$past(ch_en[c])))
                |=> $stable(remain[c*COUNT_W +: COUNT_W]));
        end
    endgenerate
endmodule

bind framing_byte_gen fbg_checker #(
    .NUM_CH  (NUM_CH),
    .COUNT_W (COUNT_W)
) u_fbg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .ch_en       (ch_en),
    .ch_byte     (ch_byte),
    .ch_ovr      (ch_ovr),
    .armed       (armed_v),
    .endless     (endless_v),
    .remain      (remain_v)
);

// File: tb/test_framing_byte_gen.sv
module test_framing_byte_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int LAT        = 6;
    localparam int FRAME_LEN  = 32;
    localparam int NV         = 18;
    localparam logic [7:0] A1C = 8'h5A;
    localparam logic [7:0] A2C = 8'hC3;

    // Stimulus/expectation table: {enables, count, disable, expected corrupt mask}
    localparam logic [16:0] TBL [NV] = '{
        {4'b0000, 8'd2, 1'b0, 4'b0000},  // R1 normal framing
        {4'b0001, 8'd2, 1'b0, 4'b0001},  // R3 rise arms ch0
        {4'b0001, 8'd2, 1'b0, 4'b0001},  // R4 second burst frame
        {4'b0001, 8'd2, 1'b0, 4'b0000},  // R4 burst ended
        {4'b0001, 8'd5, 1'b0, 4'b0000},  // R6 held high, no restart
        {4'b0000, 8'd1, 1'b0, 4'b0000},  // R6 cleared
        {4'b0001, 8'd1, 1'b0, 4'b0001},  // R6 re-armed
        {4'b0011, 8'd0, 1'b0, 4'b0010},  // R8 ch1 endless only
        {4'b0010, 8'd3, 1'b0, 4'b0010},  // R5 endless continues
        {4'b0010, 8'd3, 1'b0, 4'b0010},  // R5
        {4'b0000, 8'd3, 1'b0, 4'b0000},  // R5 enable cleared
        {4'b0100, 8'd3, 1'b0, 4'b0100},  // R7 burst of 3
        {4'b0100, 8'd1, 1'b0, 4'b0100},  // R7 count rewritten
        {4'b0100, 8'd1, 1'b0, 4'b0100},  // R7
        {4'b0100, 8'd1, 1'b0, 4'b0000},  // R7 ended after 3
        {4'b1000, 8'd2, 1'b1, 4'b0000},  // R9 disabled, frame consumed
        {4'b1000, 8'd2, 1'b0, 4'b1000},  // R9 last burst frame
        {4'b1000, 8'd2, 1'b0, 4'b0000}   // R4 ended
    };
    string tbl_tag [NV] = '{"R1", "R3", "R4", "R4", "R6", "R6", "R6", "R8", "R5",
                            "R5", "R5", "R7", "R7", "R7", "R7", "R9", "R9", "R4"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_pulse = 1'b0;
    logic [13:0]      slot_pos = 14'(FRAME_LEN);
    logic             ins_dis = 1'b0;
    logic [7:0]       cfg_a1 = A1C;
    logic [7:0]       cfg_a2 = A2C;
    logic [7:0]       cfg_count = 8'd0;
    logic [NCH-1:0]   ch_en = '0;
    logic [NCH*8-1:0] ch_byte;
    logic [NCH-1:0]   ch_ovr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    framing_byte_gen i_framing_byte_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .slot_pos    (slot_pos),
        .ins_dis     (ins_dis),
        .cfg_a1      (cfg_a1),
        .cfg_a2      (cfg_a2),
        .cfg_count   (cfg_count),
        .ch_en       (ch_en),
        .ch_byte     (ch_byte),
        .ch_ovr      (ch_ovr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare one slot of all channels against the requirement values.
    task automatic check_slot(input int j, input logic [3:0] mask, input logic dis, input string tag);
        for (int c = 0; c < NCH; c++) begin
            logic [7:0] eb;
            logic       eo;
            string      t;
            t  = (j == 11 || j == 12) ? tag : "R1";
            eo = 1'b1;
            if (j < 11)       eb = 8'hF6;
            else if (j == 11) eb = mask[c] ? A1C : 8'hF6;
            else if (j == 12) eb = mask[c] ? A2C : 8'h28;
            else if (j < 24)  eb = 8'h28;
            else begin eb = 8'h00; eo = 1'b0; end
            if (dis) begin eb = 8'h00; eo = 1'b0; t = "R9"; end
            check(t, $sformatf("ch%0d slot%0d {ovr,byte}", c, j),
                  int'({ch_ovr[c], ch_byte[c*8 +: 8]}), int'({eo, eb}));
        end
    endtask

    // Drive one full frame and check every slot at its output time.
    task automatic run_frame(input logic [3:0] mask, input logic dis, input string tag);
        for (int i = 0; i <= FRAME_LEN + LAT; i++) begin
            int j;
            @(negedge clk);
            j = i - 1 - LAT;
            if (j >= 0 && j < FRAME_LEN) check_slot(j, mask, dis, tag);
            if (i < FRAME_LEN) begin
                slot_pos    = 14'(i);
                frame_pulse = (i == 0);
            end else begin
                slot_pos    = 14'(FRAME_LEN);
                frame_pulse = 1'b0;
            end
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int lat;
        // R10: reset state with an enable held high through reset
        ch_en = 4'b0001;
        cfg_count = 8'd2;
        repeat (4) @(negedge clk);
        check("R10", "ovr during reset", int'(ch_ovr), 0);
        check("R10", "byte during reset", int'(ch_byte), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(4'b0000, 1'b0, "R10");
        ch_en = 4'b0000;
        repeat (3) @(negedge clk);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ch_en     = TBL[v][16:13];
            cfg_count = TBL[v][12:5];
            ins_dis   = TBL[v][4];
            repeat (2) @(negedge clk);
            run_frame(TBL[v][3:0], TBL[v][4], tbl_tag[v]);
        end

        // R2: latency from frame pulse to first A1 byte
        ch_en = 4'b0000;
        ins_dis = 1'b0;
        repeat (3) @(negedge clk);
        lat = -1;
        slot_pos = 14'd0;
        frame_pulse = 1'b1;
        for (int d = 0; d < 12; d++) begin
            @(negedge clk);
            if (lat < 0 && ch_ovr[0]) begin
                lat = d;
                check("R2", "first byte value", int'(ch_byte[7:0]), 'hF6);
            end
            frame_pulse = 1'b0;
            slot_pos = 14'(d + 1);
        end
        slot_pos = 14'(FRAME_LEN);
        n_checks++;
        if (lat < 5 || lat > 7) begin
            n_errors++;
            $display("FAIL R2 latency: actual=%0d expected=5..7", lat);
        end
        check("R2", "latency exact", lat, LAT);

        // R3: corrupt values read live; new shared values reach the next burst
        repeat (FRAME_LEN) @(negedge clk);
        cfg_count = 8'd1;
        ch_en = 4'b0001;
        repeat (2) @(negedge clk);
        run_frame(4'b0001, 1'b0, "R3");
        run_frame(4'b0000, 1'b0, "R4");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule